// File: doc/BRIEF.md
# Virtual-to-Physical Page Translator with Associative Buffer

This block turns a virtual address from a processor into a physical address. The upper part of the address is the page number. It is compared against every entry of a small fully associative translation buffer in parallel. On a hit the frame number comes straight out of the buffer, with no memory traffic. On a miss the block reads the page-table entry from memory, indexed by the page number from a base address held in a configuration input. It then completes the translation and loads the entry into the buffer. The in-page offset passes through unchanged.

Each page-table entry carries a valid flag, a read-only flag and a modified flag. A table-length input bounds the legal page numbers. Faults for an out-of-range page, an invalid entry and a write to a read-only page come back in place of an address. The first permitted write to a clean page writes the entry back to memory with the modified flag set, and keeps the buffered copy in step. A flush strobe empties the buffer. Two counters record lookups that hit and lookups that missed, so that the hit ratio can be measured.

Top module: `vtx_translator`

## Requirements
- R1: The offset is the low log2(PAGE_BYTES) bits of the virtual address (12 bits at the default of 4096). PAGE_BYTES must be a power of two from 512 to 8192. The physical address of a good translation is the frame number concatenated above that unchanged offset.
- R2: A page number greater than or equal to `ptab_len` answers with fault code 01 and a zero address. It makes no memory access and changes neither counter.
- R3: A lookup that hits makes no page-table memory access. A hit that needs no write-back answers with `resp_valid` in the cycle after the request is accepted.
- R4: A miss makes exactly one memory read, at `ptab_base + 4*page`. An entry is 32 bits: valid at bit 0, read-only at bit 1, modified at bit 2, and the frame number at bits [PFN_W+2:3].
- R5: An entry with its valid bit clear answers with fault code 10 and is not loaded into the buffer, so the same page misses again.
- R6: A write to a read-only page answers with fault code 11 and makes no memory write, whether it hit or missed.
- R7: The first permitted write to a page whose modified bit is clear performs one memory write of the entry with bit 2 set, then answers with the address. Later writes to that page hit with no memory write.
- R8: Misses load the buffer at a round-robin victim position that advances on every load. With 4 entries, the fifth distinct page evicts the first.
- R9: `flush` empties the buffer in one cycle. A lookup accepted in the same cycle still sees the contents from before the flush. A load that coincides with a flush is discarded, but its translation still completes.
- R10: `hit_count` and `miss_count` each rise by one for every in-range lookup that hits or misses, respectively.
- R11: After reset, `resp_valid` and `mem_req` are low, `req_ready` is high and both counters are zero.
- R12: A memory request keeps `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when a request can be accepted |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| ptab_base | input | PA_W | Physical address of page-table entry 0 |
| ptab_len | input | VPN_W+1 | Number of legal page-table entries |
| flush | input | 1 | Empty the translation buffer |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | PA_W | Physical address, zero on a fault |
| resp_fault | output | 2 | 00 none, 01 out of range, 10 invalid entry, 11 protection |
| mem_req | output | 1 | Page-table memory request |
| mem_we | output | 1 | 1 for an entry write-back |
| mem_addr | output | PA_W | Entry address |
| mem_wdata | output | 32 | Entry written back |
| mem_rdata | input | 32 | Entry read |
| mem_ack | input | 1 | Memory completes the request this cycle |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
A flush can land in the same cycle as a buffer lookup, or in the same cycle as a refill completing on a memory acknowledge. The bench provokes the first by raising `flush` with an accepted request. The memory model provokes the second by raising `flush` together with `mem_ack` on a read. In the first case the bench expects a hit with no memory read, then a miss on the next access to that page. In the second it expects a correct address and then a miss again. The constrained-random phase is checked against a buffer model in the bench that follows the same rules.

// File: rtl/vtx_pkg.sv
package vtx_pkg;

   // fault codes returned on resp_fault
   typedef enum logic [1:0] {
      FLT_NONE    = 2'b00,
      FLT_BOUND   = 2'b01,
      FLT_INVALID = 2'b10,
      FLT_PROT    = 2'b11
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_FETCH = 2'b01,
      ST_WBACK = 2'b10
   } walk_st_e;

   // page-table entry layout
   localparam int PTE_W       = 32;
   localparam int PTE_V_BIT   = 0;
   localparam int PTE_RO_BIT  = 1;
   localparam int PTE_D_BIT   = 2;
   localparam int PTE_PFN_LSB = 3;

endpackage

// File: rtl/vtx_counter.sv
module vtx_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   // R10: the count only ever moves by one step
   a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> (count == $past(count) + 1'b1));

endmodule

// File: rtl/vtx_cam.sv
module vtx_cam #(
   parameter int ENTRIES = 4,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [IDX_W-1:0] lk_idx,
   output logic [PFN_W-1:0] lk_pfn,
   output logic             lk_ro,
   output logic             lk_dirty,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_ro,
   input  logic             fill_dirty,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx
);

   logic [ENTRIES-1:0] v_q, ro_q, d_q, match;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [IDX_W-1:0]   victim_q, victim_nx;

   initial begin
      a_cfg_entries: assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
   end

   // parallel compare, one comparator per entry
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match[i] = v_q[i] && (vpn_q[i] == lk_vpn);
   end

   always_comb begin
      lk_idx   = '0;
      lk_pfn   = '0;
      lk_ro    = 1'b0;
      lk_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            lk_idx   = IDX_W'(i);
            lk_pfn   = pfn_q[i];
            lk_ro    = ro_q[i];
            lk_dirty = d_q[i];
         end
      end
   end
   assign lk_hit = |match;

   // victim pointer wrap: free for a power-of-two depth, compared otherwise
   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_wrap_pow2
      assign victim_nx = victim_q + 1'b1;
   end else begin : g_wrap_cmp
      assign victim_nx = (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q      <= '0;
         ro_q     <= '0;
         d_q      <= '0;
         victim_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i] <= '0;
            pfn_q[i] <= '0;
         end
      end else begin
         if (fill_en) victim_q <= victim_nx;
         for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && victim_q == IDX_W'(i)) begin
               v_q[i]   <= 1'b1;
               vpn_q[i] <= fill_vpn;
               pfn_q[i] <= fill_pfn;
               ro_q[i]  <= fill_ro;
               d_q[i]   <= fill_dirty;
            end else if (mark_en && mark_idx == IDX_W'(i)) begin
               d_q[i] <= 1'b1;
            end
            if (flush) v_q[i] <= 1'b0;   // flush wins over a coincident fill
         end
      end
   end

   // R8: a page never sits in two entries
   a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8: every load moves the victim pointer on
   a_r8_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (victim_q != $past(victim_q)));

   // R9: nothing hits in the cycle after a flush
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

endmodule

// File: rtl/vtx_translator.sv
module vtx_translator
   import vtx_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_BYTES  = 4096,
   parameter int TLB_ENTRIES = 4,
   parameter int CNT_W       = 16,
   localparam int OFF_W      = $clog2(PAGE_BYTES),
   localparam int VPN_W      = VA_W - OFF_W,
   localparam int PFN_W      = PA_W - OFF_W,
   localparam int LEN_W      = VPN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_va,
   input  logic             req_write,
   input  logic [PA_W-1:0]  ptab_base,
   input  logic [LEN_W-1:0] ptab_len,
   input  logic             flush,
   output logic             resp_valid,
   output logic [PA_W-1:0]  resp_pa,
   output logic [1:0]       resp_fault,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [PTE_W-1:0] mem_wdata,
   input  logic [PTE_W-1:0] mem_rdata,
   input  logic             mem_ack,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count
);

   localparam int IDX_W = $clog2(TLB_ENTRIES);

   initial begin
      a_cfg_page_size: assert (PAGE_BYTES >= 512 && PAGE_BYTES <= 8192 &&
                               (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two in 512..8192");
      a_cfg_pte_fit: assert (PFN_W + PTE_PFN_LSB <= PTE_W)
         else $error("frame number does not fit the table entry");
   end

   function automatic logic [PTE_W-1:0] mk_pte(input logic [PFN_W-1:0] pfn,
                                               input logic ro, input logic d);
      logic [PTE_W-1:0] r;
      r = '0;
      r[PTE_PFN_LSB +: PFN_W] = pfn;
      r[PTE_D_BIT]  = d;
      r[PTE_RO_BIT] = ro;
      r[PTE_V_BIT]  = 1'b1;
      return r;
   endfunction

   walk_st_e         st_q;
   logic [VPN_W-1:0] q_vpn;
   logic [OFF_W-1:0] q_off;
   logic             q_wr;
   logic [PFN_W-1:0] q_pfn;
   logic [PTE_W-1:0] q_pte;
   logic             rv_q;
   fault_e           rf_q;
   logic [PA_W-1:0]  rpa_q;

   logic [VPN_W-1:0] req_vpn;
   logic [OFF_W-1:0] req_off;
   logic             accept, in_range;
   logic             lk_hit, lk_ro, lk_dirty;
   logic [IDX_W-1:0] lk_idx;
   logic [PFN_W-1:0] lk_pfn, rd_pfn;
   logic             rd_v, rd_ro, rd_d;
   logic             fill_en, mark_en;

   assign req_vpn  = req_va[VA_W-1:OFF_W];
   assign req_off  = req_va[OFF_W-1:0];
   assign req_ready = (st_q == ST_IDLE);
   assign accept   = req_valid && req_ready;
   assign in_range = ({1'b0, req_vpn} < ptab_len);

   assign rd_pfn = mem_rdata[PTE_PFN_LSB +: PFN_W];
   assign rd_v   = mem_rdata[PTE_V_BIT];
   assign rd_ro  = mem_rdata[PTE_RO_BIT];
   assign rd_d   = mem_rdata[PTE_D_BIT];

   assign fill_en = (st_q == ST_FETCH) && mem_ack && rd_v;
   assign mark_en = accept && in_range && lk_hit && req_write && !lk_ro && !lk_dirty;

   vtx_cam #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lk_vpn     (req_vpn),
      .lk_hit     (lk_hit),
      .lk_idx     (lk_idx),
      .lk_pfn     (lk_pfn),
      .lk_ro      (lk_ro),
      .lk_dirty   (lk_dirty),
      .fill_en    (fill_en),
      .fill_vpn   (q_vpn),
      .fill_pfn   (rd_pfn),
      .fill_ro    (rd_ro),
      .fill_dirty (rd_d | (q_wr & ~rd_ro)),
      .mark_en    (mark_en),
      .mark_idx   (lk_idx)
   );

   vtx_counter #(.W(CNT_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .inc(accept && in_range && lk_hit), .count(hit_count));

   vtx_counter #(.W(CNT_W)) u_misses (
      .clk(clk), .rst_n(rst_n), .inc(accept && in_range && !lk_hit), .count(miss_count));

   // walk controller
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         q_vpn <= '0;
         q_off <= '0;
         q_wr  <= 1'b0;
         q_pfn <= '0;
         q_pte <= '0;
         rv_q  <= 1'b0;
         rf_q  <= FLT_NONE;
         rpa_q <= '0;
      end else begin
         rv_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               q_vpn <= req_vpn;
               q_off <= req_off;
               q_wr  <= req_write;
               if (!in_range) begin
                  rv_q <= 1'b1; rf_q <= FLT_BOUND; rpa_q <= '0;
               end else if (lk_hit) begin
                  if (req_write && lk_ro) begin
                     rv_q <= 1'b1; rf_q <= FLT_PROT; rpa_q <= '0;
                  end else if (req_write && !lk_dirty) begin
                     q_pfn <= lk_pfn;
                     q_pte <= mk_pte(lk_pfn, 1'b0, 1'b1);
                     st_q  <= ST_WBACK;
                  end else begin
                     rv_q <= 1'b1; rf_q <= FLT_NONE; rpa_q <= {lk_pfn, req_off};
                  end
               end else begin
                  st_q <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_ack) begin
               if (!rd_v) begin
                  rv_q <= 1'b1; rf_q <= FLT_INVALID; rpa_q <= '0; st_q <= ST_IDLE;
               end else if (q_wr && rd_ro) begin
                  rv_q <= 1'b1; rf_q <= FLT_PROT; rpa_q <= '0; st_q <= ST_IDLE;
               end else if (q_wr && !rd_d) begin
                  q_pfn <= rd_pfn;
                  q_pte <= mem_rdata | (PTE_W'(1) << PTE_D_BIT);
                  st_q  <= ST_WBACK;
               end else begin
                  rv_q <= 1'b1; rf_q <= FLT_NONE; rpa_q <= {rd_pfn, q_off}; st_q <= ST_IDLE;
               end
            end
            ST_WBACK: if (mem_ack) begin
               rv_q <= 1'b1; rf_q <= FLT_NONE; rpa_q <= {q_pfn, q_off}; st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign resp_valid = rv_q;
   assign resp_fault = rf_q;
   assign resp_pa    = rpa_q;
   assign mem_req    = (st_q != ST_IDLE);
   assign mem_we     = (st_q == ST_WBACK);
   assign mem_addr   = ptab_base + PA_W'({q_vpn, 2'b00});
   assign mem_wdata  = q_pte;

   // R2: out-of-range page answers with the bound fault next cycle
   a_r2_bound_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && ({1'b0, req_va[VA_W-1:OFF_W]} >= ptab_len))
      |=> (resp_valid && resp_fault == FLT_BOUND && !mem_req));

   // R3: a read that hits answers next cycle with no memory request
   a_r3_hit_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_range && lk_hit && !req_write) |=> (resp_valid && !mem_req));

   // R1: offset passes through a hit unchanged
   a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_range && lk_hit && !req_write)
      |=> (resp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

   // R5: an invalid entry read from memory ends in the invalid fault
   a_r5_invalid_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack && !mem_rdata[PTE_V_BIT])
      |=> (resp_valid && resp_fault == FLT_INVALID));

   // R7: every write-back carries the modified bit
   a_r7_wback_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[PTE_D_BIT]);

   // R12: a memory request holds steady until acknowledged
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/vtx_translator_bench.sv
module vtx_translator_bench;
   import vtx_pkg::*;

   localparam int VA_W = 32, PA_W = 32, VPN_W = 20, LEN_W = 21, CNT_W = 16;
   localparam int N_PT = 16, N_TLB = 4, TBL_LEN = 12;
   localparam logic [31:0] BASE = 32'h0000_4000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [VA_W-1:0] req_va = '0;
   logic [PA_W-1:0] ptab_base = BASE;
   logic [LEN_W-1:0] ptab_len = LEN_W'(TBL_LEN);
   logic flush_drv = 1'b0, flush_ack = 1'b0, flush;
   logic req_ready, resp_valid, mem_req, mem_we;
   logic [PA_W-1:0] resp_pa, mem_addr;
   logic [1:0] resp_fault;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic mem_ack = 1'b0;
   logic [CNT_W-1:0] hit_count, miss_count;

   assign flush = flush_drv | flush_ack;
   always #2 clk = ~clk;

   vtx_translator u_vtx_translator (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_write(req_write), .ptab_base(ptab_base),
      .ptab_len(ptab_len), .flush(flush), .resp_valid(resp_valid),
      .resp_pa(resp_pa), .resp_fault(resp_fault), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .hit_count(hit_count),
      .miss_count(miss_count));

   int n_chk = 0, n_fail = 0;
   int n_reads = 0, n_writes = 0, wait_cnt = 0;
   bit flush_on_ack = 1'b0;
   logic [31:0] pt [N_PT];

   // bench buffer model
   bit          tv [N_TLB];
   int          tvpn [N_TLB];
   bit          td [N_TLB];
   int          victim = 0;
   int          exp_hits = 0, exp_misses = 0;
   int          last_reads = 0, last_writes = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pte(input int pfn, input bit v, input bit ro, input bit d);
      return {9'b0, 20'(pfn), d, ro, v};
   endfunction

   // memory model for the page table
   initial begin
      forever begin
         @(negedge clk);
         flush_ack = 1'b0;
         if (mem_ack) mem_ack = 1'b0;
         else if (rst_n && mem_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
               int idx;
               idx = int'((mem_addr - BASE) >> 2);
               if (idx < 0 || idx >= N_PT) begin
                  chk(1'b0, "R4", "entry address", mem_addr, BASE);
                  idx = 0;
               end
               if (mem_we) begin
                  pt[idx] = mem_wdata;
                  n_writes++;
               end else begin
                  mem_rdata = pt[idx];
                  n_reads++;
                  if (flush_on_ack) flush_ack = 1'b1;
               end
               mem_ack  = 1'b1;
               wait_cnt = $urandom_range(0, 2);
            end
         end
      end
   end

   task automatic run_req(input int vpn, input int off, input bit wr, input bit fl);
      fault_e e_fault;
      logic [31:0] e_pa, e;
      int e_reads, e_writes, h, r0, w0, lat;
      bit got, ro;
      e_fault = FLT_NONE; e_pa = '0; e_reads = 0; e_writes = 0; h = -1;
      if (vpn >= TBL_LEN) e_fault = FLT_BOUND;
      else begin
         for (int i = 0; i < N_TLB; i++) if (tv[i] && tvpn[i] == vpn) h = i;
         e = pt[vpn]; ro = e[1];
         if (h >= 0) begin
            exp_hits++;
            if (wr && ro) e_fault = FLT_PROT;
            else begin
               if (wr && !td[h]) begin e_writes = 1; td[h] = 1'b1; end
               e_pa = {e[22:3], 12'(off)};
            end
         end else begin
            exp_misses++;
            e_reads = 1;
            if (!e[0]) e_fault = FLT_INVALID;
            else begin
               tv[victim] = 1'b1; tvpn[victim] = vpn; td[victim] = e[2] | (wr & !ro);
               victim = (victim + 1) % N_TLB;
               if (wr && ro) e_fault = FLT_PROT;
               else begin
                  if (wr && !e[2]) e_writes = 1;
                  e_pa = {e[22:3], 12'(off)};
               end
            end
            if (flush_on_ack) for (int i = 0; i < N_TLB; i++) tv[i] = 1'b0;
         end
      end
      if (fl) for (int i = 0; i < N_TLB; i++) tv[i] = 1'b0;

      @(negedge clk);
      r0 = n_reads; w0 = n_writes;
      req_valid = 1'b1; req_va = {20'(vpn), 12'(off)}; req_write = wr; flush_drv = fl;
      @(negedge clk);
      req_valid = 1'b0; flush_drv = 1'b0;
      got = 1'b0; lat = 0;
      for (int k = 0; k < 60 && !got; k++) begin
         if (resp_valid) got = 1'b1;
         else begin @(negedge clk); lat++; end
      end
      last_reads = n_reads - r0; last_writes = n_writes - w0;
      chk(got, "R3", "response strobe", got, 1);
      case (e_fault)
         FLT_BOUND:   chk(resp_fault == e_fault, "R2", "fault", resp_fault, e_fault);
         FLT_INVALID: chk(resp_fault == e_fault, "R5", "fault", resp_fault, e_fault);
         FLT_PROT:    chk(resp_fault == e_fault, "R6", "fault", resp_fault, e_fault);
         default:     chk(resp_fault == e_fault, "R1", "fault", resp_fault, e_fault);
      endcase
      chk(resp_pa == e_pa, "R1", "physical address", resp_pa, e_pa);
      chk(last_reads == e_reads, e_reads ? "R4" : "R3", "table reads", last_reads, e_reads);
      chk(last_writes == e_writes, e_fault == FLT_PROT ? "R6" : "R7", "table writes",
          last_writes, e_writes);
      if (h >= 0 && e_writes == 0 && e_fault == FLT_NONE)
         chk(lat == 0, "R3", "hit latency", lat, 0);
      if (e_writes == 1) chk(pt[vpn][2], "R7", "written modified bit", pt[vpn][2], 1);
      chk(hit_count == CNT_W'(exp_hits), "R10", "hit count", hit_count, exp_hits);
      chk(miss_count == CNT_W'(exp_misses), "R10", "miss count", miss_count, exp_misses);
   endtask

   task automatic do_flush();
      @(negedge clk); flush_drv = 1'b1;
      @(negedge clk); flush_drv = 1'b0;
      for (int i = 0; i < N_TLB; i++) tv[i] = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < N_TLB; i++) begin tv[i] = 1'b0; tvpn[i] = 0; td[i] = 1'b0; end
      pt[0] = pte('h00A11, 1, 0, 0);
      pt[1] = pte('h00B22, 1, 1, 0);
      pt[2] = pte('h00C33, 0, 0, 0);
      pt[3] = pte('h00D44, 1, 0, 1);
      for (int i = 4; i < N_PT; i++)
         pt[i] = pte(int'($urandom_range(0, 20'hFFFFF)), ($urandom_range(0, 99) < 85),
                     ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1);
      for (int i = 4; i < 9; i++) pt[i][0] = 1'b1;   // directed refill pages are valid
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk(!resp_valid, "R11", "resp_valid", resp_valid, 0);
      chk(!mem_req, "R11", "mem_req", mem_req, 0);
      chk(req_ready, "R11", "req_ready", req_ready, 1);
      chk(hit_count == 0 && miss_count == 0, "R11", "counters", hit_count, 0);

      run_req(0, 'h123, 0, 0);                    // R4 miss
      run_req(0, 'hFFF, 0, 0);                    // R3 hit
      run_req(0, 'h010, 1, 0);                    // R7 first write to clean page
      run_req(0, 'h020, 1, 0);                    // R7 no second write-back
      chk(last_writes == 0, "R7", "repeat write", last_writes, 0);
      run_req(1, 'h004, 1, 0);                    // R6 read-only on a miss
      run_req(1, 'h008, 1, 0);                    // R6 read-only on a hit
      chk(last_writes == 0, "R6", "no write on protection", last_writes, 0);
      run_req(2, 'h000, 0, 0);                    // R5 invalid
      run_req(2, 'h000, 0, 0);
      chk(last_reads == 1, "R5", "invalid not buffered", last_reads, 1);
      run_req(12, 'h000, 0, 0);                   // R2 first out-of-range page
      run_req(20'hFFFFF, 'h7, 1, 0);              // R2 far out of range
      chk(last_reads == 0, "R2", "no access out of range", last_reads, 0);

      // R8 round-robin eviction
      do_flush();
      for (int p = 4; p < 8; p++) run_req(p, 'h0, 0, 0);
      run_req(8, 'h0, 0, 0);
      run_req(5, 'h0, 0, 0);
      chk(last_reads == 0, "R8", "unevicted page hits", last_reads, 0);
      run_req(4, 'h0, 0, 0);
      chk(last_reads == 1, "R8", "oldest page evicted", last_reads, 1);

      // R9 flush coinciding with a lookup
      run_req(6, 'h0, 0, 0);
      run_req(6, 'h40, 0, 1);
      chk(last_reads == 0, "R9", "lookup sees pre-flush contents", last_reads, 0);
      run_req(6, 'h40, 0, 0);
      chk(last_reads == 1, "R9", "flushed page misses", last_reads, 1);
      // R9 flush coinciding with a refill
      flush_on_ack = 1'b1;
      run_req(3, 'h80, 0, 0);
      flush_on_ack = 1'b0;
      run_req(3, 'h80, 0, 0);
      chk(last_reads == 1, "R9", "coincident fill discarded", last_reads, 1);

      // random phase
      for (int n = 0; n < 150; n++) begin
         if ($urandom_range(0, 15) == 0) do_flush();
         run_req(int'($urandom_range(0, 13)), int'($urandom_range(0, 4095)),
                 $urandom_range(0, 1) == 1, 1'b0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule